// File: doc/BRIEF.md
# Programmable Progressive Video Timing Generator

This block produces the raster timing for a progressive video output. It counts samples along a line and lines down a frame, and from those counts drives horizontal and vertical sync, a data-enable that marks the active picture, and single-cycle markers for the first sample of each line and of each frame. Software describes the raster through a small bank of mode registers. Each line is an active width plus a total blanking interval, and each frame is an active height plus a total vertical blanking interval. The front porch and the sync pulse both lie inside that blanking.

Software stages a mode through a simple write port and then sets a commit flag. Any later write to a mode field clears the flag again. An idle generator starts the committed mode at once. A running generator keeps its current mode and picks up the new one only where a frame wraps. A control bit selects how colour planes leave the block. In parallel mode each clock carries a whole pixel. In sequential mode every raster count lasts one clock per plane, and a plane index output shows which plane is on the bus.

Top module: `vtg_top`

## Requirements
- R1: The write port stores `reg_wdata` into the field chosen by `reg_addr` on a clock where `reg_we` is high. The address codes are: 0 active width, 1 horizontal blanking, 2 horizontal front porch, 3 horizontal sync length, 4 active height, 5 vertical blanking, 6 vertical front porch, 7 vertical sync length, 8 first active line, 9 control, and 10 commit flag (bit 0).
- R2: A write to any address from 0 to 9 clears the commit flag on the next clock. A write to address 10 loads the flag from `reg_wdata[0]`.
- R3: When no mode is running and the commit flag is set with control bit 0 clear, the mode starts on the next clock, so `sof` is high in the cycle after the flag becomes set. A running generator changes mode only on the clock that would start its next frame, and it keeps the old mode for as long as the flag stays clear.
- R4: After reset, and for as long as no mode has been committed, every output is low. A mode whose control bit 0 (interlaced) is 1 is never committed.
- R5: A line lasts active width plus horizontal blanking counts. `de` is high on counts 0 to active width − 1 of every active line, and low at all other times.
- R6: `hsync` is active high. It goes high on count active width + front porch of every line and stays high for the sync length in counts.
- R7: A frame lasts active height plus vertical blanking lines. Counting lines from 0 at frame start, the active lines are those at offsets 0 to active height − 1 after the first active line, taken modulo the frame length.
- R8: `vsync` is active high. It is high for whole lines, starting at offset active height + vertical front porch after the first active line and lasting the vertical sync length in lines.
- R9: `sol` is high only in the first cycle of each line (count 0, plane 0). `sof` is high only when that cycle is also line 0.
- R10: When control bit 1 is 1 (sequential), each count lasts PLANES clocks and `plane_idx` runs 0, 1, …, PLANES − 1 within it. When bit 1 is 0 (parallel), `plane_idx` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | CW | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active picture data-enable |
| sol | output | 1 | Start-of-line marker |
| sof | output | 1 | Start-of-frame marker |
| plane_idx | output | PW | Colour plane on the bus in sequential mode |

## Verification
The mode commit and the frame wrap share one clock edge. If the new mode is loaded early, or a cycle late, the two stop lining up. The bench sets the commit flag just after a frame start and counts the cycles until the next `sof`. That count must equal the old frame length minus the cycles the write took, and every output of the frame that follows must then match the new mode, cycle by cycle. Sync pulses that end exactly on the line or frame wrap, and a zero front porch, are included so that `hsync` and `vsync` edges also fall on the same cycle as `sol` and `sof`.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   typedef enum logic [3:0] {
      RA_HACT   = 4'd0,
      RA_HBLANK = 4'd1,
      RA_HFP    = 4'd2,
      RA_HSYNC  = 4'd3,
      RA_VACT   = 4'd4,
      RA_VBLANK = 4'd5,
      RA_VFP    = 4'd6,
      RA_VSYNC  = 4'd7,
      RA_FIRST  = 4'd8,
      RA_CTRL   = 4'd9,
      RA_VALID  = 4'd10
   } reg_addr_e;

   localparam int unsigned NUM_FIELDS = 10;
   localparam int unsigned CTRL_ILACE = 0;
   localparam int unsigned CTRL_SEQ   = 1;
endpackage

// File: rtl/vtg_regfile.sv
module vtg_regfile
   import vtg_pkg::*;
#(
   parameter int unsigned CW = 12,
   parameter int unsigned AW = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [AW-1:0]                     addr,
   input  logic [CW-1:0]                     wdata,
   output logic [NUM_FIELDS-1:0][CW-1:0]     staged,
   output logic                              valid_q,
   output logic                              staged_ok
);
   localparam logic [AW-1:0] VALID_A = AW'(RA_VALID);
   localparam logic [AW-1:0] LAST_A  = AW'(NUM_FIELDS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged <= '0;
      end else if (we) begin
         for (int i = 0; i < int'(NUM_FIELDS); i++) begin
            if (addr == AW'(i)) staged[i] <= wdata;
         end
      end
   end

   // Commit flag: cleared by any field write, set only by its own address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         valid_q <= 1'b0;
      else if (we && addr == VALID_A)     valid_q <= wdata[0];
      else if (we && addr < LAST_A)       valid_q <= 1'b0;
   end

   // Interlaced modes are outside this generator and never commit
   assign staged_ok = valid_q && !staged[RA_CTRL][CTRL_ILACE];
endmodule

// File: rtl/vtg_scan.sv
module vtg_scan
   import vtg_pkg::*;
#(
   parameter int unsigned CW     = 12,
   parameter int unsigned PLANES = 3,
   parameter int unsigned PW     = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_FIELDS-1:0][CW-1:0]     staged,
   input  logic                              staged_ok,
   output logic                              running,
   output logic [NUM_FIELDS-1:0][CW-1:0]     cur,
   output logic [CW:0]                       hcnt,
   output logic [CW:0]                       vcnt,
   output logic [PW-1:0]                     pcnt
);
   localparam int unsigned TW = CW + 1;

   logic [TW-1:0] htot, vtot;
   logic          seq, last_p, last_h, last_v, frame_end, load;

   assign htot   = {1'b0, cur[RA_HACT]} + {1'b0, cur[RA_HBLANK]};
   assign vtot   = {1'b0, cur[RA_VACT]} + {1'b0, cur[RA_VBLANK]};
   assign seq    = cur[RA_CTRL][CTRL_SEQ];
   assign last_p = !seq || (pcnt == PW'(PLANES - 1));
   assign last_h = (hcnt == htot - TW'(1));
   assign last_v = (vcnt == vtot - TW'(1));
   assign frame_end = running && last_p && last_h && last_v;
   assign load      = staged_ok && (!running || frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cur     <= '0;
         hcnt    <= '0;
         vcnt    <= '0;
         pcnt    <= '0;
      end else if (load) begin
         running <= 1'b1;
         cur     <= staged;
         hcnt    <= '0;
         vcnt    <= '0;
         pcnt    <= '0;
      end else if (running) begin
         if (!last_p) begin
            pcnt <= pcnt + PW'(1);
         end else begin
            pcnt <= '0;
            if (!last_h) begin
               hcnt <= hcnt + TW'(1);
            end else begin
               hcnt <= '0;
               vcnt <= last_v ? '0 : vcnt + TW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
   import vtg_pkg::*;
#(
   parameter int unsigned CW     = 12,
   parameter int unsigned PLANES = 3,
   parameter int unsigned PW     = 2
) (
   input  logic                              running,
   input  logic [NUM_FIELDS-1:0][CW-1:0]     cur,
   input  logic [CW:0]                       hcnt,
   input  logic [CW:0]                       vcnt,
   input  logic [PW-1:0]                     pcnt,
   output logic                              hsync,
   output logic                              vsync,
   output logic                              de,
   output logic                              sol,
   output logic                              sof,
   output logic [PW-1:0]                     plane_idx
);
   localparam int unsigned TW = CW + 1;

   logic [TW-1:0] hact, vact, first, vtot, vpos;
   logic [TW-1:0] hs_on, hs_off, vs_on, vs_off;

   assign hact   = {1'b0, cur[RA_HACT]};
   assign vact   = {1'b0, cur[RA_VACT]};
   assign first  = {1'b0, cur[RA_FIRST]};
   assign vtot   = vact + {1'b0, cur[RA_VBLANK]};
   // Line offset from the first active line, wrapped into the frame
   assign vpos   = (vcnt >= first) ? vcnt - first : vcnt + vtot - first;
   assign hs_on  = hact + {1'b0, cur[RA_HFP]};
   assign hs_off = hs_on + {1'b0, cur[RA_HSYNC]};
   assign vs_on  = vact + {1'b0, cur[RA_VFP]};
   assign vs_off = vs_on + {1'b0, cur[RA_VSYNC]};

   assign de    = running && (hcnt < hact) && (vpos < vact);
   assign hsync = running && (hcnt >= hs_on) && (hcnt < hs_off);
   assign vsync = running && (vpos >= vs_on) && (vpos < vs_off);
   assign sol   = running && (hcnt == '0) && (pcnt == '0);
   assign sof   = sol && (vcnt == '0);

   generate
      if (PLANES == 1) begin : g_single_plane
         assign plane_idx = '0;
      end else begin : g_multi_plane
         assign plane_idx = running ? pcnt : '0;
      end
   endgenerate
endmodule

// File: rtl/vtg_top.sv
module vtg_top
   import vtg_pkg::*;
#(
   parameter int unsigned CW     = 12,
   parameter int unsigned AW     = 4,
   parameter int unsigned PLANES = 3,
   localparam int unsigned PW    = (PLANES > 1) ? $clog2(PLANES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [CW-1:0] reg_wdata,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic          sol,
   output logic          sof,
   output logic [PW-1:0] plane_idx
);
   generate
      if (AW < 4) begin : g_bad_aw
         $error("vtg_top: AW must reach address 10");
      end
      if (PLANES < 1) begin : g_bad_planes
         $error("vtg_top: PLANES must be at least 1");
      end
      if (CW < 2) begin : g_bad_cw
         $error("vtg_top: CW too narrow");
      end
   endgenerate

   logic [NUM_FIELDS-1:0][CW-1:0] staged, cur;
   logic                          valid_q, staged_ok, running;
   logic [CW:0]                   hcnt, vcnt;
   logic [PW-1:0]                 pcnt;

   vtg_regfile #(.CW(CW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .staged(staged), .valid_q(valid_q), .staged_ok(staged_ok)
   );

   vtg_scan #(.CW(CW), .PLANES(PLANES), .PW(PW)) u_scan (
      .clk(clk), .rst_n(rst_n), .staged(staged), .staged_ok(staged_ok),
      .running(running), .cur(cur), .hcnt(hcnt), .vcnt(vcnt), .pcnt(pcnt)
   );

   vtg_decode #(.CW(CW), .PLANES(PLANES), .PW(PW)) u_dec (
      .running(running), .cur(cur), .hcnt(hcnt), .vcnt(vcnt), .pcnt(pcnt),
      .hsync(hsync), .vsync(vsync), .de(de), .sol(sol), .sof(sof),
      .plane_idx(plane_idx)
   );
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
   import vtg_pkg::*;
#(
   parameter int unsigned CW     = 12,
   parameter int unsigned AW     = 4,
   parameter int unsigned PLANES = 3,
   parameter int unsigned PW     = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          reg_we,
   input logic [AW-1:0]                 reg_addr,
   input logic                          hsync,
   input logic                          vsync,
   input logic                          de,
   input logic                          sol,
   input logic                          sof,
   input logic [PW-1:0]                 plane_idx,
   input logic                          running,
   input logic                          valid_q,
   input logic [NUM_FIELDS-1:0][CW-1:0] cur
);
   // R2
   valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr < AW'(NUM_FIELDS)) |=> !valid_q);

   // R3
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> ($stable(cur) || sof));

   // R3
   start_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> sof);

   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !(hsync || vsync || de || sol || sof));

   // R4
   no_ilace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> !cur[RA_CTRL][CTRL_ILACE]);

   // R9
   frame_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> (sol && plane_idx == '0));

   // R10
   parallel_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !cur[RA_CTRL][CTRL_SEQ]) |-> (plane_idx == '0));

   // R10
   plane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cur[RA_CTRL][CTRL_SEQ] && plane_idx != PW'(PLANES - 1))
      |=> (plane_idx == $past(plane_idx) + PW'(1)));
endmodule

bind vtg_top vtg_chk #(.CW(CW), .AW(AW), .PLANES(PLANES), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .hsync(hsync), .vsync(vsync), .de(de), .sol(sol), .sof(sof),
   .plane_idx(plane_idx), .running(running), .valid_q(valid_q), .cur(cur)
);

// File: tb/sim_vtg_top.sv
`timescale 1ns/1ps
module sim_vtg_top;
   localparam int CW = 12;
   localparam int AW = 4;
   localparam int NP = 3;
   localparam int PW = 2;

   // Field order follows the address codes: hact hblank hfp hsync vact vblank vfp vsync first ctrl
   localparam int MODES [4][10] = '{
      '{4, 4, 1, 2, 3, 3, 1, 1, 0, 0},
      '{3, 3, 1, 1, 2, 4, 1, 2, 0, 2},
      '{5, 3, 2, 1, 4, 2, 0, 2, 2, 0},
      '{2, 2, 0, 1, 1, 3, 1, 1, 0, 0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [CW-1:0] reg_wdata = '0;
   logic          hsync, vsync, de, sol, sof;
   logic [PW-1:0] plane_idx;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   vtg_top #(.CW(CW), .AW(AW), .PLANES(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .hsync(hsync), .vsync(vsync), .de(de),
      .sol(sol), .sof(sof), .plane_idx(plane_idx)
   );

   task automatic note(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      reg_we    = 1'b1;
      reg_addr  = AW'(a);
      reg_wdata = CW'(d);
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic program_row(input int r, input int ctrl);
      for (int a = 0; a < 9; a++) wr(a, MODES[r][a]);
      wr(9, ctrl);
   endtask

   function automatic int frame_len(input int r);
      int np;
      np = MODES[r][9][1] ? NP : 1;
      return (MODES[r][0] + MODES[r][1]) * (MODES[r][4] + MODES[r][5]) * np;
   endfunction

   task automatic wait_sof(output int cnt);
      cnt = 0;
      while (!sof && cnt < 5000) begin
         @(negedge clk);
         cnt++;
      end
      note(sof, "R3 sof timeout", sof, 1);
   endtask

   // Walk one frame from the current sof cycle and compare every output
   task automatic check_frame(input int r);
      int hact, htot, hfp, hs, vact, vtot, vfp, vs, first, np, vpos;
      logic [6:0] expv, actv;
      hact = MODES[r][0]; htot = hact + MODES[r][1];
      hfp = MODES[r][2]; hs = MODES[r][3];
      vact = MODES[r][4]; vtot = vact + MODES[r][5];
      vfp = MODES[r][6]; vs = MODES[r][7];
      first = MODES[r][8];
      np = MODES[r][9][1] ? NP : 1;
      for (int v = 0; v < vtot; v++) begin
         vpos = (v >= first) ? v - first : v + vtot - first;
         for (int h = 0; h < htot; h++) begin
            for (int p = 0; p < np; p++) begin
               expv[6] = (h >= hact + hfp) && (h < hact + hfp + hs);
               expv[5] = (vpos >= vact + vfp) && (vpos < vact + vfp + vs);
               expv[4] = (h < hact) && (vpos < vact);
               expv[3] = (h == 0) && (p == 0);
               expv[2] = (h == 0) && (p == 0) && (v == 0);
               expv[1:0] = 2'(p);
               actv = {hsync, vsync, de, sol, sof, plane_idx};
               n_chk++;
               if (actv !== expv) begin
                  n_bad++;
                  $display("FAIL R5/R6/R7/R8/R9/R10 row %0d v=%0d h=%0d p=%0d act=%b exp=%b",
                           r, v, h, p, actv, expv);
               end
               @(negedge clk);
            end
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cnt;
      logic any;
      repeat (3) @(negedge clk);
      // R4: outputs low out of reset
      note({hsync, vsync, de, sol, sof, plane_idx} == '0, "R4 reset state",
           {hsync, vsync, de, sol, sof, plane_idx}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: an interlaced mode with the commit flag set never starts
      program_row(0, 1);
      wr(10, 1);
      any = 1'b0;
      for (int i = 0; i < 100; i++) begin
         any |= hsync | vsync | de | sol | sof;
         @(negedge clk);
      end
      note(!any, "R4 interlaced rejected", any, 0);

      // R1/R2/R3: clearing bit 0 of control clears the flag; re-commit starts at once
      wr(9, 0);
      wr(10, 1);
      note(!sof, "R3 not before commit", sof, 0);
      @(negedge clk);
      note(sof, "R3 idle start next cycle", sof, 1);
      check_frame(0);
      check_frame(0);

      // Table walk: stage each mode while the previous one runs
      for (int r = 1; r < 4; r++) begin
         program_row(r, MODES[r][9]);
         wait_sof(cnt);
         wr(10, 1);
         wait_sof(cnt);
         note(cnt == frame_len(r - 1) - 1, "R3 switch at frame wrap",
              cnt, frame_len(r - 1) - 1);
         check_frame(r);
      end

      // R2/R3: field write without re-commit leaves the running mode untouched
      wr(0, 7);
      wait_sof(cnt);
      check_frame(3);
      check_frame(3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule